// File: doc/BRIEF.md
# Victim Buffer Beside a Direct-Mapped Tag Store

This block keeps the tags of a direct-mapped primary cache next to a small fully associative buffer. The buffer holds the lines that the primary most recently pushed out. The block tracks line addresses and valid bits only. It stores no data and performs no write-back. A request carries a line address, meaning the byte address with the offset bits already removed. The low bits of that address select the primary slot, and the high bits form the primary tag.

Each request is looked up in the primary slot and in every buffer entry at the same time. One cycle later the block reports one of three outcomes:
- **Primary hit:** nothing changes.
- **Buffer hit:** the requested line moves back into its primary slot, and the line it displaces takes the buffer entry that just matched.
- **Full miss:** the block raises a fetch request toward the next level and installs the line in the primary. A valid line displaced from the primary is written into the buffer slot named by a ring pointer, overwriting the oldest insertion once the buffer is full.

Together these rules stop two lines that share a primary slot from missing on every access.

Top module: `vcache_tags`

## Requirements
- R1: While reset is held and on the first cycle after it, rsp_valid, rsp_kind and fetch_req are 0. Reset empties both structures, so the first request to any line is a full miss.
- R2: Every cycle with req_valid high yields exactly one response, with rsp_valid high on the following cycle. A cycle without a request yields rsp_valid low, rsp_kind 2'b00 and fetch_req low. rsp_kind encodes primary hit as 2'b01, buffer hit as 2'b10 and full miss as 2'b11.
- R3: A request whose index (the low IDX_W bits) selects a valid primary slot holding its tag (the remaining high bits) is a primary hit, and no state changes.
- R4: On a full miss, fetch_req is high in the response cycle and fetch_line equals the requested line. fetch_req is low in every other cycle. The line then sits in the primary, so an immediate repeat is a primary hit.
- R5: A full miss that displaces a valid primary line writes that line into the buffer slot at the ring pointer and advances the pointer, wrapping after VC_N-1. A miss into an invalid primary slot writes nothing and leaves the pointer where it was.
- R6: A buffer hit installs the requested line in its primary slot. The matching buffer entry receives the displaced primary line, or becomes invalid if that slot was empty. The ring pointer does not move, and a line is never held in both structures.
- R7: Two lines whose addresses differ by exactly 2^IDX_W alternate as full miss, full miss, then buffer hits on every later access.
- R8: With all VC_N buffer entries written, the next insertion overwrites the entry inserted earliest, and a request to that line becomes a full miss.
- R9: Lines with different index bits never displace one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_line | input | LINE_W | Line address of the request |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_kind | output | 2 | 01 primary hit, 10 buffer hit, 11 full miss, 00 idle |
| fetch_req | output | 1 | Next-level fetch needed (full miss) |
| fetch_line | output | LINE_W | Line to fetch; meaningful when fetch_req is high |

## Verification
The properties assume that no request arrives during reset, and that fetched data returns outside this block, so a new lookup may follow a miss on the very next cycle. The properties also rely on lines entering the structures only through this block's own misses, which keeps any address from being held twice. The stimulus drives requests only after reset is released and issues them back to back or with idle gaps. It uses a narrow address range, a few tags on a few indices, so that conflicts, swaps and wrap-around of the ring pointer all occur often.

// File: rtl/vcache_tags.sv
module vcache_tags #(
  parameter int LINE_W = 12,
  parameter int IDX_W  = 4,
  parameter int VC_N   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic              fetch_req,
  output logic [LINE_W-1:0] fetch_line
);
  localparam int TAG_W = LINE_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int PW    = (VC_N > 1) ? $clog2(VC_N) : 1;
  localparam logic [1:0] K_PHIT = 2'b01, K_VHIT = 2'b10, K_MISS = 2'b11;

  logic [TAG_W-1:0]  ptag [SETS];
  logic [SETS-1:0]   pval;
  logic [LINE_W-1:0] vline [VC_N];
  logic [VC_N-1:0]   vval;
  logic [PW-1:0]     vptr;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              p_hit, v_hit, d_val;
  logic [LINE_W-1:0] displaced;
  logic [VC_N-1:0]   vmatch;
  logic [PW-1:0]     vsel;

  assign idx       = req_line[IDX_W-1:0];
  assign tag       = req_line[LINE_W-1:IDX_W];
  assign d_val     = pval[idx];
  assign p_hit     = d_val && (ptag[idx] == tag);
  assign displaced = {ptag[idx], idx};
  assign v_hit     = |vmatch;

  for (genvar k = 0; k < VC_N; k++) begin : g_cmp
    assign vmatch[k] = vval[k] && (vline[k] == req_line);
  end

  always_comb begin
    vsel = '0;
    for (int k = 0; k < VC_N; k++)
      if (vmatch[k]) vsel = PW'(k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pval       <= '0;
      vval       <= '0;
      vptr       <= '0;
      rsp_valid  <= 1'b0;
      rsp_kind   <= 2'b00;
      fetch_req  <= 1'b0;
      fetch_line <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_kind  <= 2'b00;
      fetch_req <= 1'b0;
      if (req_valid) begin
        if (p_hit) begin
          rsp_kind <= K_PHIT;
        end else begin
          ptag[idx] <= tag;
          pval[idx] <= 1'b1;
          if (v_hit) begin
            rsp_kind    <= K_VHIT;
            vline[vsel] <= displaced;
            vval[vsel]  <= d_val;
          end else begin
            rsp_kind   <= K_MISS;
            fetch_req  <= 1'b1;
            fetch_line <= req_line;
            if (d_val) begin
              vline[vptr] <= displaced;
              vval[vptr]  <= 1'b1;
              vptr        <= (vptr == PW'(VC_N - 1)) ? '0 : vptr + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/vcache_tags_chk.sv
module vcache_tags_chk #(
  parameter int LINE_W = 12,
  parameter int VC_N   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [LINE_W-1:0] req_line,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic              fetch_req,
  input logic [LINE_W-1:0] fetch_line,
  input logic [VC_N-1:0]   vmatch
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_kind == 2'b00 && !fetch_req));
  assert_kind_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_kind != 2'b00);
  assert_fetch_only_on_miss_R4: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> (rsp_valid && rsp_kind == 2'b11));
  assert_miss_fetches_line_R4: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && rsp_valid && rsp_kind == 2'b11) |-> (fetch_req && fetch_line == $past(req_line)));
  assert_repeat_is_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && rsp_valid && $past(req_valid) && $past(req_valid, 2) &&
     $past(req_line) == $past(req_line, 2)) |-> rsp_kind == 2'b01);
  assert_single_copy_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vmatch));
endmodule

bind vcache_tags vcache_tags_chk #(.LINE_W(LINE_W), .VC_N(VC_N)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .fetch_req(fetch_req),
  .fetch_line(fetch_line), .vmatch(vmatch)
);

// File: tb/vcache_tags_test.sv
`timescale 1ns/1ps
module vcache_tags_test;
  localparam int LINE_W = 12;
  localparam int IDX_W  = 4;
  localparam int VC_N   = 8;
  localparam int SETS   = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [LINE_W-1:0] req_line = '0;
  logic rsp_valid, fetch_req;
  logic [1:0] rsp_kind;
  logic [LINE_W-1:0] fetch_line;

  always #2 clk = ~clk;

  vcache_tags #(.LINE_W(LINE_W), .IDX_W(IDX_W), .VC_N(VC_N)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .fetch_req(fetch_req),
    .fetch_line(fetch_line));

  int checks = 0, failures = 0;
  bit done = 0;

  int pt [SETS];
  bit pv [SETS];
  int vl [VC_N];
  bit vv [VC_N];
  int vp;

  bit exp_v;
  int exp_k, exp_line;
  string exp_tag;

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, expv, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < SETS; i++) begin pt[i] = 0; pv[i] = 0; end
    for (int j = 0; j < VC_N; j++) begin vl[j] = 0; vv[j] = 0; end
    vp = 0;
    exp_v = 0;
  endtask

  function automatic int model_access(input int line);
    int ix, tg, h, k;
    ix = line % SETS;
    tg = line / SETS;
    if (pv[ix] && pt[ix] == tg) return 1;
    h = -1;
    for (int j = 0; j < VC_N; j++) if (vv[j] && vl[j] == line) h = j;
    if (h >= 0) begin
      k = 2;
      vl[h] = pt[ix] * SETS + ix;
      vv[h] = pv[ix];
    end else begin
      k = 3;
      if (pv[ix]) begin
        vl[vp] = pt[ix] * SETS + ix;
        vv[vp] = 1;
        vp = (vp + 1) % VC_N;
      end
    end
    pt[ix] = tg;
    pv[ix] = 1;
    return k;
  endfunction

  task automatic compare_now();
    string r;
    if (exp_v) begin
      r = (exp_k == 1) ? "R3" : (exp_k == 2) ? "R6" : "R4";
      chk(rsp_valid == 1'b1, {exp_tag, "/R2 rsp_valid"}, rsp_valid, 1);
      chk(rsp_kind == 2'(exp_k), {exp_tag, "/", r, " kind"}, rsp_kind, exp_k);
      chk(fetch_req == (exp_k == 3), {exp_tag, "/R4 fetch_req"}, fetch_req, exp_k == 3);
      if (exp_k == 3)
        chk(fetch_line == LINE_W'(exp_line), {exp_tag, "/R4 fetch_line"}, fetch_line, exp_line);
    end else begin
      chk(!rsp_valid && rsp_kind == 2'b00 && !fetch_req, {exp_tag, "/R2 idle"},
          {rsp_valid, rsp_kind, fetch_req}, 0);
    end
  endtask

  task automatic step(input bit v, input int line, input string tg);
    @(negedge clk);
    compare_now();
    req_valid = v;
    req_line  = LINE_W'(line);
    exp_v     = v;
    exp_tag   = tg;
    exp_line  = line;
    if (v) exp_k = model_access(line);
  endtask

  task automatic expect_kind(input int line, input int k, input string tg);
    step(1, line, tg);
    chk(exp_k == k, {tg, " scenario expectation"}, exp_k, k);
  endtask

  task automatic do_reset();
    step(0, 0, "R2");
    rst = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!rsp_valid && rsp_kind == 2'b00 && !fetch_req, "R1 in reset",
        {rsp_valid, rsp_kind, fetch_req}, 0);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    exp_tag = "R1";
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_clear();
    exp_tag = "R1";
    repeat (3) @(negedge clk);
    chk(!rsp_valid && rsp_kind == 2'b00 && !fetch_req, "R1 in reset",
        {rsp_valid, rsp_kind, fetch_req}, 0);
    rst = 1'b0;

    expect_kind(12'h005, 3, "R1");
    expect_kind(12'h005, 1, "R3");
    step(0, 0, "R2");
    expect_kind(12'h006, 3, "R9");
    expect_kind(12'h005, 1, "R9");
    expect_kind(12'h105, 3, "R7");
    expect_kind(12'h205, 3, "R7");
    for (int i = 0; i < 6; i++) begin
      expect_kind(12'h105, 2, "R7");
      expect_kind(12'h205, 2, "R7");
    end
    expect_kind(12'h205, 1, "R6");
    expect_kind(12'h005, 2, "R6");
    expect_kind(12'h006, 1, "R9");

    do_reset();
    for (int t = 1; t <= VC_N + 2; t++) expect_kind(t * SETS + 1, 3, "R5");
    expect_kind(1 * SETS + 1, 3, "R8");
    expect_kind(2 * SETS + 1, 3, "R8");
    expect_kind(4 * SETS + 1, 2, "R8");

    do_reset();
    for (int s = 1; s <= VC_N; s++) expect_kind(s, 3, "R5");
    for (int t = 1; t <= VC_N + 1; t++) expect_kind(t * SETS, 3, "R5");
    expect_kind(1 * SETS, 2, "R5");
    expect_kind(2 * SETS, 2, "R5");

    do_reset();
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 4) == 0) step(0, 0, "R2");
      else step(1, $urandom_range(0, 3) * SETS + $urandom_range(0, 3), "R2");
    end
    step(0, 0, "R2");
    step(0, 0, "R2");
    finish_run();
  end
endmodule